// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of small saturating counters arranged as rows and columns. A slice of the low bits of the branch address picks the row. A global history register holds the outcomes of the most recently resolved branches, and its value picks the column. The same branch can therefore get a different prediction depending on how the preceding branches went. With HIST_W history bits, CTR_W-bit counters and 2^IDX_W rows, the table holds 2^HIST_W × CTR_W × 2^IDX_W bits. The default is 2 history bits, 2-bit counters and 16 rows, which gives 128 bits.

The lookup is purely combinational. The fetch stage presents an address and gets the predicted direction in the same cycle. It also gets the history value that was used, and it keeps that value with the branch until the branch resolves. At resolution the back end sends an update with the branch address, the actual outcome and the saved history. The counter that made the prediction then moves one step toward the outcome, and the outcome is shifted into the global history.

Top module: `corr_bpred`

## Requirements
- R1: While `rst_n` is low, and after it is released, every counter holds the weakly not-taken value 2^(CTR_W-1)−1 (1 for 2-bit counters) and the history `lk_hist` is zero.
- R2: `lk_taken` is 1 exactly when the selected counter is at least 2^(CTR_W-1). It follows `lk_addr` in the same cycle, with no clock edge in between.
- R3: The row is taken from address bits [ADDR_LSB+IDX_W-1:ADDR_LSB], which are bits [5:2] by default. Addresses that agree in these bits share a row, and every other address bit has no effect.
- R4: Within the row, the column is the current history value. Each history value selects its own counter, and `lk_hist` shows that value.
- R5: On a clock edge with `up_valid` high, exactly one counter is written: the one at the row of `up_addr` and column `up_hist`. It increments when `up_taken` is 1 and decrements when `up_taken` is 0.
- R6: Counters saturate. An increment at 2^CTR_W−1 and a decrement at 0 leave the value unchanged.
- R7: On each valid update the history becomes {history[HIST_W-2:0], up_taken}, and the oldest bit is dropped. Without an update the history holds its value.
- R8: A lookup in the same cycle as an update sees the counter and history values from before that update.
- R9: With 2-bit counters, a counter that predicts strongly taken keeps predicting taken after one not-taken update. It needs two consecutive not-taken updates to flip to not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | ADDR_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_hist | output | HIST_W | History value used for this lookup |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |
| up_hist | input | HIST_W | History captured when the branch was predicted |

## Verification
The bench looks up an entry in the same cycle as its update. A design that writes through would return the new value there, and the bench would see it. It pushes a counter down to zero and past it. A counter that wraps would then predict taken after a single taken update. It reads through aliased addresses and through addresses that differ only in the low bits, which catches a row taken from the wrong address slice. It also changes the history while keeping the address fixed, which exposes a table that ignores the history or shifts it the wrong way. It walks a strongly taken counter through one miss and then a second, and a counter that moves too far on a single miss would flip after the first.

// File: rtl/bp_pkg.sv
package bp_pkg;

   function automatic int weak_not_taken(input int ctr_bits);
      return (1 << (ctr_bits - 1)) - 1;
   endfunction

   function automatic int max_count(input int ctr_bits);
      return (1 << ctr_bits) - 1;
   endfunction

endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
   parameter int HIST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   output logic [HIST_W-1:0] hist
);

   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_d;

   generate
      if (HIST_W == 1) begin : g_single
         assign hist_d = shift_bit;
      end else begin : g_multi
         assign hist_d = {hist_q[HIST_W-2:0], shift_bit};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         hist_q <= '0;
      else if (shift_en)
         hist_q <= hist_d;
   end

   assign hist = hist_q;

endmodule

// File: rtl/bp_sat_step.sv
module bp_sat_step #(
   parameter int CTR_W = 2
) (
   input  logic [CTR_W-1:0] cur,
   input  logic             inc,
   output logic [CTR_W-1:0] nxt
);

   localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};

   always_comb begin
      if (inc)
         nxt = (cur == TOP) ? cur : cur + 1'b1;
      else
         nxt = (cur == '0) ? cur : cur - 1'b1;
   end

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
   parameter int IDX_W  = 4,
   parameter int HIST_W = 2,
   parameter int CTR_W  = 2,
   localparam int SEL_W = IDX_W + HIST_W,
   localparam int N_ENT = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_row,
   input  logic [HIST_W-1:0] rd_col,
   output logic [CTR_W-1:0]  rd_ctr,
   input  logic              wr_valid,
   input  logic [IDX_W-1:0]  wr_row,
   input  logic [HIST_W-1:0] wr_col,
   input  logic [CTR_W-1:0]  wr_val,
   output logic [CTR_W-1:0]  wr_old,
   output logic [N_ENT-1:0]  wr_sel
);

   localparam logic [CTR_W-1:0] RST_VAL = CTR_W'(bp_pkg::weak_not_taken(CTR_W));

   logic [CTR_W-1:0] ctr_q [N_ENT];
   logic [SEL_W-1:0] rd_sel;
   logic [SEL_W-1:0] wr_ptr;

   assign rd_sel = {rd_row, rd_col};
   assign wr_ptr = {wr_row, wr_col};
   assign rd_ctr = ctr_q[rd_sel];
   assign wr_old = ctr_q[wr_ptr];

   generate
      for (genvar e = 0; e < N_ENT; e++) begin : g_ent
         assign wr_sel[e] = wr_valid && (wr_ptr == SEL_W'(e));

         always_ff @(posedge clk) begin
            if (!rst_n)
               ctr_q[e] <= RST_VAL;
            else if (wr_sel[e])
               ctr_q[e] <= wr_val;
         end
      end
   endgenerate

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
   parameter int ADDR_W   = 32,
   parameter int ADDR_LSB = 2,
   parameter int IDX_W    = 4,
   parameter int HIST_W   = 2,
   parameter int CTR_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_taken,
   output logic [HIST_W-1:0] lk_hist,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic              up_taken,
   input  logic [HIST_W-1:0] up_hist
);

   localparam int ROW_HI = ADDR_LSB + IDX_W - 1;
   localparam int N_ENT  = 1 << (IDX_W + HIST_W);

   generate
      if (HIST_W < 1 || HIST_W > 8)       begin : g_bad_hist $error("HIST_W out of range"); end
      if (CTR_W < 1 || CTR_W > 8)         begin : g_bad_ctr  $error("CTR_W out of range");  end
      if (IDX_W < 1 || IDX_W + HIST_W > 12) begin : g_bad_idx $error("table too large");   end
      if (ADDR_LSB < 1 || ROW_HI >= ADDR_W - 1) begin : g_bad_addr $error("row slice outside address"); end
   endgenerate

   logic [IDX_W-1:0]  lk_row;
   logic [IDX_W-1:0]  up_row;
   logic [CTR_W-1:0]  lk_ctr;
   logic [CTR_W-1:0]  wr_old;
   logic [CTR_W-1:0]  wr_new;
   logic [N_ENT-1:0]  wr_sel;
   logic [HIST_W-1:0] ghr;
   logic              unused_addr_bits;

   assign lk_row = lk_addr[ROW_HI:ADDR_LSB];
   assign up_row = up_addr[ROW_HI:ADDR_LSB];
   assign unused_addr_bits = ^{lk_addr[ADDR_W-1:ROW_HI+1], lk_addr[ADDR_LSB-1:0],
                               up_addr[ADDR_W-1:ROW_HI+1], up_addr[ADDR_LSB-1:0]};

   bp_ghr #(.HIST_W(HIST_W)) u_ghr (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (up_valid),
      .shift_bit(up_taken),
      .hist     (ghr)
   );

   bp_ctr_table #(.IDX_W(IDX_W), .HIST_W(HIST_W), .CTR_W(CTR_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_row  (lk_row),
      .rd_col  (ghr),
      .rd_ctr  (lk_ctr),
      .wr_valid(up_valid),
      .wr_row  (up_row),
      .wr_col  (up_hist),
      .wr_val  (wr_new),
      .wr_old  (wr_old),
      .wr_sel  (wr_sel)
   );

   bp_sat_step #(.CTR_W(CTR_W)) u_step (
      .cur(wr_old),
      .inc(up_taken),
      .nxt(wr_new)
   );

   assign lk_taken = lk_ctr[CTR_W-1];
   assign lk_hist  = ghr;

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
   parameter int HIST_W = 2,
   parameter int CTR_W  = 2,
   parameter int N_ENT  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_valid,
   input logic              up_taken,
   input logic [HIST_W-1:0] lk_hist,
   input logic [N_ENT-1:0]  wr_sel,
   input logic [CTR_W-1:0]  wr_old,
   input logic [CTR_W-1:0]  wr_new
);

   localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};

   assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> lk_hist == HIST_W'({$past(lk_hist), $past(up_taken)}));

   assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(lk_hist));

   assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel) && (up_valid == ($countones(wr_sel) == 1)));

   assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && wr_old != TOP) |-> wr_new == wr_old + 1'b1);

   assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && wr_old != '0) |-> wr_new == wr_old - 1'b1);

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_taken && wr_old == TOP) |-> wr_new == TOP);

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_taken && wr_old == '0) |-> wr_new == '0);

endmodule

bind corr_bpred bp_checker #(.HIST_W(HIST_W), .CTR_W(CTR_W), .N_ENT(N_ENT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .up_valid(up_valid),
   .up_taken(up_taken),
   .lk_hist (lk_hist),
   .wr_sel  (wr_sel),
   .wr_old  (wr_old),
   .wr_new  (wr_new)
);

// File: tb/sim_corr_bpred.sv
`timescale 1ns/1ps
module sim_corr_bpred;

   localparam int HW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   lk_addr = '0;
   logic          lk_taken;
   logic [HW-1:0] lk_hist;
   logic          up_valid = 1'b0;
   logic [31:0]   up_addr = '0;
   logic          up_taken = 1'b0;
   logic [HW-1:0] up_hist = '0;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   corr_bpred u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_addr(lk_addr), .lk_taken(lk_taken), .lk_hist(lk_hist),
      .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken), .up_hist(up_hist)
   );

   // {up_valid, up_addr[7:0], up_taken, up_hist, lk_addr[7:0], exp_taken, exp_hist}
   localparam int NV = 10;
   localparam logic [22:0] VEC [NV] = '{
      {1'b0, 8'h00, 1'b0, 2'd0, 8'h10, 1'b0, 2'd0},  // R1 reset state
      {1'b1, 8'h10, 1'b1, 2'd0, 8'h10, 1'b0, 2'd0},  // R8 old value on same-cycle update
      {1'b0, 8'h00, 1'b0, 2'd0, 8'h10, 1'b0, 2'd1},  // R4 new history, other counter
      {1'b1, 8'h10, 1'b1, 2'd0, 8'h10, 1'b0, 2'd1},  // R5 second taken update
      {1'b1, 8'h20, 1'b0, 2'd3, 8'h10, 1'b0, 2'd3},  // R7 history 11
      {1'b1, 8'h20, 1'b0, 2'd2, 8'h10, 1'b0, 2'd2},  // R7 oldest bit dropped
      {1'b1, 8'h10, 1'b1, 2'd0, 8'h10, 1'b1, 2'd0},  // R2 counter 3 predicts taken
      {1'b1, 8'h10, 1'b0, 2'd0, 8'h10, 1'b0, 2'd1},  // R4 column 1 untouched
      {1'b1, 8'h10, 1'b0, 2'd0, 8'h20, 1'b0, 2'd2},  // R6 row 8 at zero
      {1'b0, 8'h00, 1'b0, 2'd0, 8'h10, 1'b0, 2'd0}   // R5 3->2->1 not taken
   };

   task automatic check(input string req, input logic [HW:0] act, input logic [HW:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: got taken/hist=%b expected %b", req, act, exp);
      end
   endtask

   task automatic cycle(input logic v, input logic [31:0] ua, input logic t,
                        input logic [HW-1:0] h, input logic [31:0] la);
      @(negedge clk);
      up_valid = v; up_addr = ua; up_taken = t; up_hist = h; lk_addr = la;
      #1;
   endtask

   task automatic upd(input logic [31:0] a, input logic t);
      cycle(1'b1, a, t, 2'd0, 32'h0);
   endtask

   task automatic clear_hist();
      for (int i = 0; i < HW; i++) upd(32'h3C, 1'b0);
   endtask

   task automatic look(input string req, input logic [31:0] a, input logic ep);
      cycle(1'b0, 32'h0, 1'b0, 2'd0, a);
      check(req, {lk_taken, lk_hist}, {ep, 2'd0});
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check("R1 hist/pred during reset", {lk_taken, lk_hist}, 3'b000);
      rst_n = 1'b1;

      for (int k = 0; k < NV; k++) begin
         cycle(VEC[k][22], {24'h0, VEC[k][21:14]}, VEC[k][13], VEC[k][12:11],
               {24'h0, VEC[k][10:3]});
         check($sformatf("R2/R4/R7 vector %0d", k), {lk_taken, lk_hist}, VEC[k][2:0]);
      end

      // R1: drive a counter to strongly taken, then reset it back
      upd(32'h10, 1'b1); upd(32'h10, 1'b1);
      clear_hist();
      look("R1 precondition strong taken", 32'h10, 1'b1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1;
      look("R1 counter back to weak not-taken", 32'h10, 1'b0);

      // R3: aliasing and ignored address bits
      upd(32'h10, 1'b1); upd(32'h10, 1'b1);
      clear_hist();
      look("R3 alias via upper bits", 32'h50, 1'b1);
      look("R3 low bits ignored", 32'h13, 1'b1);
      look("R3 neighbour row unaffected", 32'h14, 1'b0);

      // R9: two misses needed to flip
      upd(32'h10, 1'b0);
      clear_hist();
      look("R9 one miss keeps taken", 32'h10, 1'b1);
      upd(32'h10, 1'b0);
      clear_hist();
      look("R9 second miss flips", 32'h10, 1'b0);

      // R6: saturation at zero
      upd(32'h10, 1'b0); upd(32'h10, 1'b0); upd(32'h10, 1'b0);
      upd(32'h10, 1'b1);
      clear_hist();
      look("R6 no underflow, one taken", 32'h10, 1'b0);
      upd(32'h10, 1'b1);
      clear_hist();
      look("R6 two taken from zero", 32'h10, 1'b1);

      // R6: saturation at top
      upd(32'h10, 1'b1); upd(32'h10, 1'b1); upd(32'h10, 1'b1);
      upd(32'h10, 1'b0);
      clear_hist();
      look("R6 no overflow, one miss", 32'h10, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule